// File: doc/BRIEF.md
# Gigabit Ethernet Ordered-Set Generator

This block produces the configuration and idle ordered sets of a 1000BASE-X link. Each cycle it emits one 8-bit code group and a control flag. The output goes to an external 8B/10B encoder running at the 125 MHz code-group rate, which gives a 1.25 Gbps serial line. In configuration mode it sends four-group sets that carry a 16-bit configuration word. Two set variants are sent in turn, without a break. In idle mode it sends two-group sets. The idle variant is picked from the encoder's running disparity, so that a positive disparity is corrected and a negative one is kept.

The mode select, the configuration word and the disparity input are sampled only on the clock edge that begins a new ordered set. A change made while a set is in progress does not affect that set. A one-bit marker flags the first code group of every set, so a downstream checker can confirm even-boundary alignment. The configuration word is sent low byte first.

Top module: `gige_oset_gen`

## Requirements
- R1: The control flag `ctrl_o` is high only on the comma code group K28.5 (0xBC). Every other group has `ctrl_o` low.
- R2: Configuration variant one is the sequence 0xBC (K), 0xB5 (D21.5), configuration low byte, configuration high byte.
- R3: Configuration variant two is the sequence 0xBC (K), 0x42 (D2.2), configuration low byte, configuration high byte.
- R4: Consecutive configuration sets alternate between variant one and variant two. The first configuration set after reset, or after any idle set, is variant one.
- R5: An idle set is two groups. It is 0xBC then 0xC5 (D5.6, correcting) when `rd_pos_i` is high at the edge that starts the set, and 0xBC then 0x50 (D16.2, preserving) otherwise.
- R6: The configuration word is sent as `cfg_reg_i[7:0]` in the third group and `cfg_reg_i[15:8]` in the fourth group.
- R7: `cfg_mode_i`, `cfg_reg_i` and `rd_pos_i` are sampled only on the edge that starts a set. Changes to them during a set have no effect on that set's groups or length.
- R8: While `rst_ni` is low, `data_o`, `ctrl_o` and `set_start_o` are zero. The first set starts on the first clock edge after reset is released. That set treats the running disparity as negative, so an idle set is the preserving form.
- R9: `set_start_o` is high exactly on the first group of each set, and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Code-group clock (125 MHz in the system) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | 1 selects configuration sets, 0 selects idle sets |
| cfg_reg_i | input | 16 | Configuration word carried in configuration sets |
| rd_pos_i | input | 1 | Encoder running disparity, 1 when positive |
| data_o | output | 8 | Code group byte (bits HGF EDCBA) |
| ctrl_o | output | 1 | Control (K) identifier for `data_o` |
| set_start_o | output | 1 | High on the first code group of each ordered set |

## Verification
The assertions check four properties on every cycle: the control flag appears only on the comma, every set starts with the comma, the start marker never repeats on consecutive cycles, and each set's length matches the variant byte that follows its comma. Some behaviours can only be shown by the bench's scenarios. These are the exact payload bytes and their order, the alternation between variants, the choice of idle form from disparity sampled at the set boundary, and the immunity of a set to input changes made while it is in progress.

// File: rtl/gige_oset_pkg.sv
package gige_oset_pkg;
  localparam logic [7:0] K28_5 = 8'hBC;
  localparam logic [7:0] D21_5 = 8'hB5;
  localparam logic [7:0] D2_2  = 8'h42;
  localparam logic [7:0] D5_6  = 8'hC5;
  localparam logic [7:0] D16_2 = 8'h50;

  typedef enum logic {
    MODE_IDLE = 1'b0,
    MODE_CFG  = 1'b1
  } oset_mode_e;
endpackage

// File: rtl/gige_oset_ctrl.sv
module gige_oset_ctrl
  import gige_oset_pkg::*;
#(
  parameter int CFG_BYTES = 2,
  localparam int CFG_W    = 8 * CFG_BYTES,
  localparam int CFG_LEN  = 2 + CFG_BYTES,
  localparam int POS_W    = $clog2(CFG_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_mode_i,
  input  logic [CFG_W-1:0] cfg_reg_i,
  input  logic             rd_pos_i,
  output logic             valid_o,
  output logic [POS_W-1:0] pos_o,
  output oset_mode_e       mode_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             var2_o,
  output logic             corr_o
);
  logic             valid_q;
  logic [POS_W-1:0] pos_q;
  oset_mode_e       mode_q;
  logic [CFG_W-1:0] cfg_q;
  logic             var2_q;
  logic             corr_q;
  logic             last_grp;
  logic             boundary;

  always_comb begin
    if (mode_q == MODE_CFG) last_grp = (pos_q == POS_W'(CFG_LEN - 1));
    else                    last_grp = (pos_q == POS_W'(1));
  end

  assign boundary = !valid_q || last_grp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pos_q   <= '0;
      mode_q  <= MODE_IDLE;
      cfg_q   <= '0;
      var2_q  <= 1'b0;
      corr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b1;
      if (boundary) begin
        pos_q  <= '0;
        mode_q <= oset_mode_e'(cfg_mode_i);
        cfg_q  <= cfg_reg_i;
        // first set after reset assumes negative disparity
        corr_q <= valid_q & rd_pos_i;
        // alternate only across back-to-back config sets
        var2_q <= cfg_mode_i & valid_q & (mode_q == MODE_CFG) & ~var2_q;
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  assign valid_o = valid_q;
  assign pos_o   = pos_q;
  assign mode_o  = mode_q;
  assign cfg_o   = cfg_q;
  assign var2_o  = var2_q;
  assign corr_o  = corr_q;
endmodule

// File: rtl/gige_oset_sel.sv
module gige_oset_sel
  import gige_oset_pkg::*;
#(
  parameter int CFG_BYTES = 2,
  localparam int CFG_W    = 8 * CFG_BYTES,
  localparam int CFG_LEN  = 2 + CFG_BYTES,
  localparam int POS_W    = $clog2(CFG_LEN)
) (
  input  logic             valid_i,
  input  logic [POS_W-1:0] pos_i,
  input  oset_mode_e       mode_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             var2_i,
  input  logic             corr_i,
  output logic [7:0]       data_o,
  output logic             ctrl_o,
  output logic             start_o
);
  logic [7:0] cfg_byte [CFG_BYTES];

  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_byte
    assign cfg_byte[g] = cfg_i[8*g +: 8];
  end

  always_comb begin
    data_o  = 8'h00;
    ctrl_o  = 1'b0;
    start_o = 1'b0;
    if (valid_i) begin
      if (pos_i == '0) begin
        data_o  = K28_5;
        ctrl_o  = 1'b1;
        start_o = 1'b1;
      end else if (pos_i == POS_W'(1)) begin
        if (mode_i == MODE_CFG) data_o = var2_i ? D2_2 : D21_5;
        else                    data_o = corr_i ? D5_6 : D16_2;
      end else begin
        for (int b = 0; b < CFG_BYTES; b++) begin
          if (pos_i == POS_W'(b + 2)) data_o = cfg_byte[b];
        end
      end
    end
  end
endmodule

// File: rtl/gige_oset_gen.sv
module gige_oset_gen
  import gige_oset_pkg::*;
#(
  parameter int CFG_BYTES = 2,
  localparam int CFG_W    = 8 * CFG_BYTES,
  localparam int CFG_LEN  = 2 + CFG_BYTES,
  localparam int POS_W    = $clog2(CFG_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_mode_i,
  input  logic [CFG_W-1:0] cfg_reg_i,
  input  logic             rd_pos_i,
  output logic [7:0]       data_o,
  output logic             ctrl_o,
  output logic             set_start_o
);
  logic             valid;
  logic [POS_W-1:0] pos;
  oset_mode_e       mode;
  logic [CFG_W-1:0] cfg;
  logic             var2;
  logic             corr;

  gige_oset_ctrl #(.CFG_BYTES(CFG_BYTES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_mode_i (cfg_mode_i),
    .cfg_reg_i  (cfg_reg_i),
    .rd_pos_i   (rd_pos_i),
    .valid_o    (valid),
    .pos_o      (pos),
    .mode_o     (mode),
    .cfg_o      (cfg),
    .var2_o     (var2),
    .corr_o     (corr)
  );

  gige_oset_sel #(.CFG_BYTES(CFG_BYTES)) u_sel (
    .valid_i (valid),
    .pos_i   (pos),
    .mode_i  (mode),
    .cfg_i   (cfg),
    .var2_i  (var2),
    .corr_i  (corr),
    .data_o  (data_o),
    .ctrl_o  (ctrl_o),
    .start_o (set_start_o)
  );
endmodule

// File: rtl/gige_oset_chk.sv
module gige_oset_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] data_o,
  input logic       ctrl_o,
  input logic       set_start_o
);
  assert_kflag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o |-> data_o == 8'hBC);

  assert_start_comma_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_start_o |-> ctrl_o);

  assert_no_double_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_start_o |=> !set_start_o);

  assert_idle_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(set_start_o) && !ctrl_o && (data_o == 8'hC5 || data_o == 8'h50)) |=> set_start_o);

  assert_cfg_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(set_start_o) && !ctrl_o && (data_o == 8'hB5 || data_o == 8'h42)) |=> !set_start_o);
endmodule

bind gige_oset_gen gige_oset_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_o      (data_o),
  .ctrl_o      (ctrl_o),
  .set_start_o (set_start_o)
);

// File: tb/gige_oset_gen_test.sv
module gige_oset_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [15:0] cfg_reg = 16'h0000;
  logic        rd_pos = 1'b0;
  logic [7:0]  data;
  logic        ctrl;
  logic        set_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit first_set = 1'b1;
  bit prev_cfg = 1'b0;
  bit var2 = 1'b0;

  typedef struct {
    logic [7:0] d;
    logic       k;
    logic       s;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  gige_oset_gen uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_mode_i  (cfg_mode),
    .cfg_reg_i   (cfg_reg),
    .rd_pos_i    (rd_pos),
    .data_o      (data),
    .ctrl_o      (ctrl),
    .set_start_o (set_start)
  );

  task automatic push(input logic [7:0] d, input logic k, input logic s, input string req);
    exp_t e;
    e.d = d; e.k = k; e.s = s; e.req = req;
    exp_q.push_back(e);
  endtask

  // called at a negedge just before the edge that starts the set
  task automatic send_set(input bit m, input logic [15:0] cfg, input bit rd, input string tag);
    int len;
    bit corr;
    cfg_mode = m; cfg_reg = cfg; rd_pos = rd;
    corr = first_set ? 1'b0 : rd;
    if (m) var2 = prev_cfg ? ~var2 : 1'b0;
    push(8'hBC, 1'b1, 1'b1, {"R1 R9 ", tag});
    if (m) begin
      push(var2 ? 8'h42 : 8'hB5, 1'b0, 1'b0, {var2 ? "R3 R4 " : "R2 R4 ", tag});
      push(cfg[7:0],  1'b0, 1'b0, {"R6 low ", tag});
      push(cfg[15:8], 1'b0, 1'b0, {"R6 high ", tag});
      len = 4;
    end else begin
      push(corr ? 8'hC5 : 8'h50, 1'b0, 1'b0, {"R5 ", tag});
      len = 2;
    end
    prev_cfg = m;
    first_set = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin  // R7: scramble inputs mid-set
        cfg_mode = ~m; cfg_reg = ~cfg; rd_pos = ~rd;
      end
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (data !== e.d || ctrl !== e.k || set_start !== e.s) begin
        errors++;
        $display("FAIL %s: got d=%h k=%b s=%b exp d=%h k=%b s=%b",
                 e.req, data, ctrl, set_start, e.d, e.k, e.s);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (data !== 8'h00 || ctrl !== 1'b0 || set_start !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: got d=%h k=%b s=%b exp d=00 k=0 s=0", data, ctrl, set_start);
    end
    rst_n = 1'b1;
    send_set(1'b0, 16'h0000, 1'b1, "R8 first idle");
    send_set(1'b0, 16'h0000, 1'b1, "idle pos R7");
    send_set(1'b0, 16'h0000, 1'b0, "idle neg R7");
    send_set(1'b1, 16'h1234, 1'b0, "cfg A R7");
    send_set(1'b1, 16'h1234, 1'b1, "cfg B R7");
    send_set(1'b1, 16'hA5C3, 1'b0, "cfg C R7");
    send_set(1'b1, 16'h00FF, 1'b0, "cfg D R7");
    send_set(1'b0, 16'h0000, 1'b1, "idle after cfg");
    send_set(1'b1, 16'hBC42, 1'b1, "cfg restart R4");
    send_set(1'b1, 16'h8001, 1'b0, "cfg restart 2");
    send_set(1'b0, 16'h0000, 1'b0, "idle neg 2");
    // reset again mid-stream, then config first
    rst_n = 1'b0;
    @(negedge clk);
    exp_q.delete();
    checks++;
    if (data !== 8'h00 || ctrl !== 1'b0 || set_start !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset2: got d=%h k=%b s=%b exp d=00 k=0 s=0", data, ctrl, set_start);
    end
    first_set = 1'b1; prev_cfg = 1'b0; var2 = 1'b0;
    rst_n = 1'b1;
    send_set(1'b1, 16'h5AA5, 1'b1, "R8 first cfg");
    send_set(1'b1, 16'h5AA5, 1'b1, "cfg second");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule